// File: doc/BRIEF.md
# SPI Flash Streaming Read Engine

This block is the host side of a serial NOR flash read path. A client presents a 24-bit start address and a byte count with a one-cycle `start` pulse. The engine lowers chip select and clocks out the fast-read opcode, the address and one dummy byte. It then keeps SCK running and gathers the returned bytes for as long as the count requires. Each gathered byte leaves on a valid/ready stream. The flash itself advances its internal address and wraps from the top of its space back to zero, so one request of any length needs only one address phase.

SCK is generated by dividing the system clock: each half period lasts `CLK_DIV` system cycles. A parameter selects whether SCK rests low (mode 0) or high (mode 3). In both modes MOSI moves while SCK is low, and MISO is captured on the rising edge. When the consumer stops taking bytes, the engine parks SCK at the next byte boundary instead of dropping data. It resumes when the waiting byte has been taken.

Top module: `spi_fastread_ctrl`

## Requirements
- R1: After chip select falls, the first 8 bits seen on MOSI at rising SCK edges are the opcode 0x0B, MSB first.
- R2: The next 24 bits on MOSI are the start address, bit 23 first and bit 0 last.
- R3: The next 8 bits (the dummy byte) are all zero, and MOSI stays low for the rest of the data phase.
- R4: While chip select is high, SCK rests at 0 when `SCK_IDLE_HIGH`=0 and at 1 when it is 1. MOSI only changes while SCK is low. MISO is captured at rising SCK edges.
- R5: A request for N bytes produces a single chip-select low period with exactly 40+8N rising SCK edges. This holds even when the burst crosses the top flash address.
- R6: The received bytes, assembled MSB first, appear on `out_data` in order. Byte i is the flash content at (start + i), with the flash wrapping from 0x3FFFFF to 0x000000.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: A `start` with a byte count of zero leaves chip select high and `busy` low.
- R9: `busy` rises in the cycle after an accepted `start` and falls in the same cycle that chip select returns high.
- R10: While a received byte waits unaccepted in the data phase, SCK produces no rising edge, and chip select stays low.
- R11: A `start` pulse while `busy` is high is ignored: the current transfer keeps its address and count, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| start_addr | input | ADDR_W (24) | First byte address of the burst |
| byte_count | input | CNT_W (16) | Number of bytes to fetch; zero is rejected |
| busy | output | 1 | High from request acceptance until chip select is released |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | `out_data` holds a byte not yet taken |
| out_ready | input | 1 | Consumer takes the byte when high together with `out_valid` |

## Verification
The bound assertions check the following on every cycle:
- the SCK rest level whenever chip select is high;
- that MOSI is steady across each high SCK phase;
- that `busy` tracks chip select;
- that a zero count is rejected;
- that a waiting output byte is held;
- that no rising SCK edge occurs while a data byte waits.

Only the bench scenarios can show the serial content: the opcode, the address, the zero dummy byte, the exact edge count per burst, and that the stream returns the right bytes across the wrap point. The bench's flash model decodes the header itself, which is also how it shows that a start pulse during a transfer leaves that transfer unchanged. Both SCK polarities run side by side on the same stimulus and random backpressure.

// File: rtl/fr_pkg.sv
package fr_pkg;

   // Sequencer states of the read engine.
   typedef enum logic [2:0] {
      ST_IDLE,   // chip select high
      ST_LEAD,   // chip select low, SCK at rest, setup time
      ST_LOW,    // low half of a bit cell, MOSI presented
      ST_HIGH,   // high half of a bit cell, MISO captured on entry
      ST_HOLD,   // parked at a byte boundary, SCK high
      ST_TAIL    // SCK back at rest, chip select still low
   } fr_state_t;

   localparam logic [7:0] FR_OPCODE = 8'h0B;

endpackage

// File: rtl/fr_halfper.sv
// Half-period timer: pulses tick on the last cycle of each SCK half period.
module fr_halfper #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_direct
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick = en;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign tick = en && (cnt == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!en || tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/fr_hdr_shift.sv
// Header shifter: opcode, address and dummy bits leave MSB first; zeros follow.
module fr_hdr_shift #(
   parameter int HDR_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [HDR_W-1:0] load_val,
   input  logic             shift,
   output logic             mosi
);
   logic [HDR_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh <= '0;
      else if (load)
         sh <= load_val;
      else if (shift)
         sh <= {sh[HDR_W-2:0], 1'b0};
   end

   assign mosi = sh[HDR_W-1];
endmodule

// File: rtl/fr_rx_byte.sv
// Receive assembler with a single-entry valid/ready output register.
module fr_rx_byte #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              last,
   input  logic              miso,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_valid
);
   logic [BYTE_W-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         if (sample)
            sh <= {sh[BYTE_W-3:0], miso};
         if (sample && last) begin
            out_data  <= {sh, miso};
            out_valid <= 1'b1;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_fastread_ctrl.sv
module spi_fastread_ctrl
   import fr_pkg::*;
#(
   parameter int CLK_DIV       = 2,
   parameter int ADDR_W        = 24,
   parameter int CNT_W         = 16,
   parameter int DUMMY_BYTES   = 1,
   parameter bit SCK_IDLE_HIGH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              busy,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [7:0]        out_data,
   output logic              out_valid,
   input  logic              out_ready
);
   localparam int HDR_W = 8 + ADDR_W + 8 * DUMMY_BYTES;
   localparam int HC_W  = $clog2(HDR_W);
   localparam logic IDLE_LVL = SCK_IDLE_HIGH;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (ADDR_W < 8 || (ADDR_W % 8) != 0) begin : g_bad_addr
         $error("ADDR_W must be a positive multiple of 8");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (DUMMY_BYTES < 0) begin : g_bad_dummy
         $error("DUMMY_BYTES must not be negative");
      end
   endgenerate

   fr_state_t        state, state_d;
   logic [HC_W-1:0]  hdr_cnt;
   logic             in_data;
   logic [2:0]       bit_cnt;
   logic [CNT_W-1:0] bytes_left;
   logic             tick, timed, accept, can_go, rx_sample, tx_shift;

   assign accept    = (state == ST_IDLE) && start && (byte_count != '0);
   assign can_go    = !out_valid || out_ready;
   assign timed     = (state == ST_LEAD) || (state == ST_LOW) ||
                      (state == ST_HIGH) || (state == ST_TAIL);
   assign rx_sample = (state == ST_LOW) && tick && in_data;
   assign tx_shift  = (state == ST_HIGH) && tick;

   fr_halfper #(.DIV(CLK_DIV)) u_div (
      .clk (clk),
      .rst_n (rst_n),
      .en  (timed),
      .tick (tick)
   );

   fr_hdr_shift #(.HDR_W(HDR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val ({FR_OPCODE, start_addr, {(8 * DUMMY_BYTES){1'b0}}}),
      .shift    (tx_shift),
      .mosi     (spi_mosi)
   );

   fr_rx_byte #(.BYTE_W(8)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (rx_sample),
      .last      (bit_cnt == 3'd7),
      .miso      (spi_miso),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_valid (out_valid)
   );

   // Next-state decision; a new data byte starts only when the output slot is free.
   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE: if (accept) state_d = ST_LEAD;
         ST_LEAD: if (tick)   state_d = ST_LOW;
         ST_LOW:  if (tick)   state_d = ST_HIGH;
         ST_HIGH: begin
            if (tick) begin
               if (!in_data) begin
                  if (hdr_cnt == '0)
                     state_d = can_go ? ST_LOW : ST_HOLD;
                  else
                     state_d = ST_LOW;
               end else if (bit_cnt == 3'd7) begin
                  if (bytes_left == '0)
                     state_d = ST_TAIL;
                  else
                     state_d = can_go ? ST_LOW : ST_HOLD;
               end else begin
                  state_d = ST_LOW;
               end
            end
         end
         ST_HOLD: if (can_go) state_d = ST_LOW;
         ST_TAIL: if (tick)   state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   // State and registered pin levels derived from the next state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         spi_cs_n <= 1'b1;
         busy     <= 1'b0;
         spi_sck  <= IDLE_LVL;
      end else begin
         state    <= state_d;
         spi_cs_n <= (state_d == ST_IDLE);
         busy     <= (state_d != ST_IDLE);
         unique case (state_d)
            ST_HIGH, ST_HOLD: spi_sck <= 1'b1;
            ST_LOW:           spi_sck <= 1'b0;
            default:          spi_sck <= IDLE_LVL;
         endcase
      end
   end

   // Header, bit and byte bookkeeping.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_cnt    <= '0;
         in_data    <= 1'b0;
         bit_cnt    <= '0;
         bytes_left <= '0;
      end else if (accept) begin
         hdr_cnt    <= HC_W'(HDR_W - 1);
         in_data    <= 1'b0;
         bit_cnt    <= '0;
         bytes_left <= byte_count;
      end else begin
         if (rx_sample && (bit_cnt == 3'd7))
            bytes_left <= bytes_left - 1'b1;
         if (tx_shift) begin
            if (!in_data) begin
               if (hdr_cnt == '0)
                  in_data <= 1'b1;
               else
                  hdr_cnt <= hdr_cnt - 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
   parameter int CNT_W     = 16,
   parameter bit IDLE_HIGH = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] byte_count,
   input logic             busy,
   input logic             cs_n,
   input logic             sck,
   input logic             mosi,
   input logic [7:0]       out_data,
   input logic             out_valid,
   input logic             out_ready,
   input logic             in_data
);
   // R4
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sck == IDLE_HIGH));

   // R4
   mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sck && $past(sck) && !$past(cs_n)) |-> $stable(mosi));

   // R9
   busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);

   // R8
   zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (byte_count == '0)) |=> (!busy && cs_n));

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R10
   park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && in_data && !cs_n) |=> !$rose(sck));
endmodule

bind spi_fastread_ctrl fr_chk #(
   .CNT_W     (CNT_W),
   .IDLE_HIGH (SCK_IDLE_HIGH)
) u_fr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .byte_count (byte_count),
   .busy       (busy),
   .cs_n       (spi_cs_n),
   .sck        (spi_sck),
   .mosi       (spi_mosi),
   .out_data   (out_data),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .in_data    (in_data)
);

// File: tb/spi_fastread_ctrl_bench.sv
// Behavioural flash: decodes the header, drives MISO on falling SCK edges.
module spi_fastread_ctrl_flash (
   input  logic        sck,
   input  logic        cs_n,
   input  logic        mosi,
   output logic        miso,
   output int          rises,
   output logic [39:0] hdr,
   output int          mosi_hi
);
   logic in_txn = 1'b0;

   function automatic logic [7:0] content(input logic [23:0] a);
      logic [21:0] w;
      w = a[21:0];
      return w[7:0] ^ {w[13:8], w[21:20]} ^ {2'b00, w[19:14]} ^ 8'h5C;
   endfunction

   initial begin
      miso = 1'b0; rises = 0; hdr = '0; mosi_hi = 0;
   end

   always @(negedge cs_n or posedge cs_n or posedge sck) begin
      if (cs_n === 1'b1) begin
         in_txn = 1'b0;
      end else if (cs_n === 1'b0) begin
         if (!in_txn) begin
            in_txn = 1'b1; rises = 0; hdr = '0; mosi_hi = 0;
         end else begin
            if (rises < 40) hdr = {hdr[38:0], mosi};
            else if (mosi) mosi_hi = mosi_hi + 1;
            rises = rises + 1;
         end
      end
   end

   always @(negedge sck) begin
      if (cs_n === 1'b0 && rises >= 40) begin
         int k;
         logic [7:0] b;
         k = rises - 40;
         b = content(hdr[31:8] + 24'(k / 8));
         miso = b[7 - (k % 8)];
      end
   end
endmodule

module spi_fastread_ctrl_bench;
   localparam int DIV = 2;
   localparam int CW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [23:0] st_addr = '0;
   logic [CW-1:0] st_cnt = '0;
   logic out_ready = 1'b0;

   logic busy0, cs0, sck0, mosi0, miso0, valid0;
   logic busy1, cs1, sck1, mosi1, miso1, valid1;
   logic [7:0] data0, data1;
   int rises0, rises1, hi0, hi1;
   logic [39:0] hdr0, hdr1;

   int checks = 0, errors = 0, cyc = 0;
   int rdy_pct = 100;
   bit force_stall = 1'b0;
   int got0 = 0, got1 = 0;
   logic [23:0] cur_addr = '0;

   always #4 clk = ~clk;

   spi_fastread_ctrl #(.CLK_DIV(DIV), .CNT_W(CW), .SCK_IDLE_HIGH(1'b0)) u_spi_fastread_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(st_addr), .byte_count(st_cnt),
      .busy(busy0), .spi_cs_n(cs0), .spi_sck(sck0), .spi_mosi(mosi0), .spi_miso(miso0),
      .out_data(data0), .out_valid(valid0), .out_ready(out_ready));

   spi_fastread_ctrl #(.CLK_DIV(DIV), .CNT_W(CW), .SCK_IDLE_HIGH(1'b1)) u_m3 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(st_addr), .byte_count(st_cnt),
      .busy(busy1), .spi_cs_n(cs1), .spi_sck(sck1), .spi_mosi(mosi1), .spi_miso(miso1),
      .out_data(data1), .out_valid(valid1), .out_ready(out_ready));

   spi_fastread_ctrl_flash u_flash0 (.sck(sck0), .cs_n(cs0), .mosi(mosi0), .miso(miso0),
      .rises(rises0), .hdr(hdr0), .mosi_hi(hi0));
   spi_fastread_ctrl_flash u_flash1 (.sck(sck1), .cs_n(cs1), .mosi(mosi1), .miso(miso1),
      .rises(rises1), .hdr(hdr1), .mosi_hi(hi1));

   function automatic logic [7:0] expect_byte(input logic [23:0] a);
      logic [21:0] w;
      w = a[21:0];
      return w[7:0] ^ {w[13:8], w[21:20]} ^ {2'b00, w[19:14]} ^ 8'h5C;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Stream sink: decide ready first, then log what the coming edge accepts.
   always @(negedge clk) begin
      if (force_stall) out_ready = 1'b0;
      else out_ready = (($urandom % 100) < rdy_pct);
      if (rst_n && valid0 && out_ready) begin
         chk(data0 == expect_byte(cur_addr + 24'(got0)), "R6 mode0 byte", data0,
             expect_byte(cur_addr + 24'(got0)));
         got0++;
      end
      if (rst_n && valid1 && out_ready) begin
         chk(data1 == expect_byte(cur_addr + 24'(got1)), "R6 mode3 byte", data1,
             expect_byte(cur_addr + 24'(got1)));
         got1++;
      end
   end

   task automatic run_read(input logic [23:0] addr, input int n, input bit poke, input bit stall);
      int r0;
      logic [7:0] d0;
      @(negedge clk);
      got0 = 0; got1 = 0; cur_addr = addr;
      force_stall = stall;
      start = 1'b1; st_addr = addr; st_cnt = CW'(n);
      @(negedge clk);
      start = 1'b0;
      // R9: busy and chip select one cycle after acceptance
      chk(busy0 && !cs0 && busy1 && !cs1, "R9 busy on accept", {busy0, cs0, busy1, cs1}, 4'b1010);
      if (poke) begin
         repeat (30) @(negedge clk);
         start = 1'b1; st_addr = addr ^ 24'h12_3456; st_cnt = CW'(n + 5);
         @(negedge clk);
         start = 1'b0;
      end
      if (stall) begin
         while (!valid0) @(negedge clk);
         r0 = rises0; d0 = data0;
         repeat (100) @(negedge clk);
         // R10: parked clock, chip select held
         chk(rises0 == r0 && !cs0, "R10 sck parked", rises0, r0);
         // R7: byte held while not ready
         chk(valid0 && data0 == d0, "R7 byte held", data0, d0);
         force_stall = 1'b0;
      end
      while (busy0 || busy1) @(negedge clk);
      chk(cs0 && cs1, "R9 cs released with busy", {cs0, cs1}, 2'b11);
      while (valid0 || valid1) @(negedge clk);
      chk(hdr0[39:32] == 8'h0B && hdr1[39:32] == 8'h0B, "R1 opcode", hdr0[39:32], 8'h0B);
      chk(hdr0[31:8] == addr && hdr1[31:8] == addr, "R2 address", hdr0[31:8], addr);
      chk(hdr0[7:0] == 8'h00 && hdr1[7:0] == 8'h00 && hi0 == 0 && hi1 == 0,
          "R3 dummy and data-phase mosi", {hdr0[7:0], 8'(hi0)}, 0);
      chk(rises0 == 40 + 8 * n && rises1 == 40 + 8 * n, "R5 edge count", rises0, 40 + 8 * n);
      chk(got0 == n && got1 == n, "R6 byte count", got0, n);
      chk(sck0 == 1'b0 && sck1 == 1'b1, "R4 rest level", {sck0, sck1}, 2'b01);
      if (poke) begin
         repeat (12) @(negedge clk);
         // R11: no second transfer after the ignored start
         chk(cs0 && cs1 && !busy0 && !busy1, "R11 start ignored", {cs0, busy0}, 2'b10);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      // R4 and R9 reset state
      chk(cs0 && cs1 && !busy0 && !busy1 && !valid0 && !valid1, "R9 reset outputs",
          {cs0, cs1, busy0, busy1}, 4'b1100);
      chk(sck0 == 1'b0 && sck1 == 1'b1, "R4 reset rest level", {sck0, sck1}, 2'b01);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_read(24'h00_0000, 1, 1'b0, 1'b0);
      run_read(24'h3F_FFFD, 6, 1'b0, 1'b0);   // R6 wrap through the top address
      run_read(24'hFF_FFFE, 4, 1'b0, 1'b0);   // R2 upper address bits pass through
      rdy_pct = 30;
      run_read(24'h12_3400, 9, 1'b0, 1'b0);

      // R8: zero count
      @(negedge clk);
      start = 1'b1; st_addr = 24'h00_0100; st_cnt = '0;
      @(negedge clk);
      start = 1'b0;
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 20; i++) begin
            if (!cs0 || !cs1 || busy0 || busy1) quiet = 1'b0;
            @(negedge clk);
         end
         chk(quiet, "R8 zero count rejected", quiet, 1);
      end

      rdy_pct = 100;
      run_read(24'h00_1000, 3, 1'b0, 1'b1);   // R10 / R7 directed stall
      run_read(24'h20_0040, 5, 1'b1, 1'b0);   // R11 start during busy

      for (int t = 0; t < 30; t++) begin
         logic [23:0] a;
         int n;
         a = 24'($urandom);
         if (($urandom % 4) == 0) a = {a[23:22], 22'h3F_FFF0 + 22'($urandom % 16)};
         n = 1 + int'($urandom % 12);
         rdy_pct = 20 + int'($urandom % 81);
         run_read(a, n, 1'b0, 1'b0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule